// File: doc/BRIEF.md
# Two-Stage Programmable Crosspoint Router

This block is the control and routing core of a crosspoint switch with eight main outputs, one auxiliary output and eight main data inputs. Every output also has a private expansion input, which is used when crosspoint devices are chained into a larger matrix. The main outputs take their expansion bits from `exp_in[n]`. The auxiliary output takes its expansion bit from `aux_in`. Data lanes are single bits and pass from input to output through combinational logic only. There is no register anywhere on the data path.

The routing is programmed in two steps.

- **Staging.** Software presents an output number on `oa` and a source code on `ia`. It then raises `load`, which writes the code into that output's entry of a staging store. Raising `stage_aux` writes the code into the auxiliary output's entry instead.
- **Commit.** Entries can be staged for several outputs without disturbing any traffic. A `commit` strobe then copies the whole staging store into the active store, so all outputs change over in the same cycle.

The control levels are sampled on the rising clock. Holding the stage and commit controls high makes both stores follow the address buses every cycle.

Top module: `xpt_switch_ctrl`

## Requirements
- R1: While reset is low, and after its release until the first commit, every entry of both stores holds the quiet code. As a result `out` is 8'hFF and `aux_out` is 1.
- R2: A cycle with `load` high writes `ia` only into the staging entry of output `oa`, where `oa` values 0..7 name outputs 0..7. All other entries keep their codes.
- R3: While `commit` is low, no activity on `load`, `stage_aux`, `oa` or `ia` changes the routing of any output.
- R4: A cycle with `commit` high copies all nine staging entries into the active store. The outputs use the new routing from the next rising clock edge, and every output switches at that edge.
- R5: An active code from 4'b0000 to 4'b0111 routes main input `main_in[code]` to the output.
- R6: An active code of the form 4'b10xx routes `exp_in[n]` to main output n, and routes `aux_in` to `aux_out`.
- R7: An active code of the form 4'b11xx drives the output to a constant 1.
- R8: A cycle with `stage_aux` high writes `ia` into the auxiliary output's staging entry.
- R9: When `load` or `stage_aux` is high in the same cycle as `commit`, the value written in that cycle is the one committed.
- R10: Holding `load` and `commit` high makes the path transparent. Each cycle, output `oa` takes the code presented on `ia` in that cycle.
- R11: Once routing is committed, a change of the selected data input reaches the output with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the control levels |
| rst_n | input | 1 | Synchronous reset, active low |
| main_in | input | 8 | Main data inputs |
| exp_in | input | 8 | Expansion inputs, one per main output |
| aux_in | input | 1 | Expansion input of the auxiliary output |
| oa | input | 3 | Number of the output being staged |
| ia | input | 4 | Source code being staged |
| load | input | 1 | Stage `ia` into the entry of output `oa` |
| stage_aux | input | 1 | Stage `ia` into the auxiliary entry |
| commit | input | 1 | Copy the staging store into the active store |
| out | output | 8 | Main data outputs |
| aux_out | output | 1 | Auxiliary data output |

## Verification
The bench stages codes for several outputs and then idles. A design that routed straight from the staging store would change `out` before the commit. The bench raises stage and commit together in one cycle. A design that committed the old staging contents would lag one programming step behind. The bench drives the expansion and quiet codes on the auxiliary entry and on the main entries. A design that decoded only the top address bit, or that sent the auxiliary output's expansion lane to `exp_in`, would show a wrong `aux_out` or drive a main output from the wrong lane. In transparent mode the bench steps `ia` through every main code with fresh data on each step. After a mid-run reset it checks that every output has gone quiet.

// File: rtl/xpt_pkg.sv
// Shared definitions for the crosspoint router.
// Assumes a source code whose top bit picks main against special sources,
// and whose next bit picks expansion against quiet.
package xpt_pkg;
    typedef enum logic [1:0] {
        SRC_MAIN  = 2'd0,
        SRC_EXP   = 2'd2,
        SRC_QUIET = 2'd3
    } src_kind_t;

    // Classify a source code from its two top bits.
    function automatic src_kind_t kind_of(input logic hi, input logic lo);
        if (!hi)
            return SRC_MAIN;
        else if (!lo)
            return SRC_EXP;
        else
            return SRC_QUIET;
    endfunction
endpackage

// File: rtl/xpt_stage_store.sv
// First configuration stage: one code entry per output, plus a last entry
// for the auxiliary output. It exports the value the store takes at the next
// edge, so that a commit in the same cycle sees this cycle's write.
// Assumes that oa only names main outputs.
module xpt_stage_store #(
    parameter int N_OUT = 8,
    parameter int OA_W  = 3,
    parameter int IA_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OA_W-1:0]           oa,
    input  logic [IA_W-1:0]           ia,
    input  logic                      load,
    input  logic                      stage_aux,
    output logic [(N_OUT+1)*IA_W-1:0] staged_flat
);
    localparam int N_ENT = N_OUT + 1;
    localparam logic [IA_W-1:0] QUIET = {2'b11, {(IA_W-2){1'b0}}};

    logic [N_ENT-1:0][IA_W-1:0] st_q;
    logic [N_ENT-1:0][IA_W-1:0] st_next;

    // Apply this cycle's writes to the held entries.
    always_comb begin
        st_next = st_q;
        if (load)
            st_next[int'(oa)] = ia;
        if (stage_aux)
            st_next[N_OUT] = ia;
    end

    // Hold the staged entries; reset makes every entry quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++)
                st_q[i] <= QUIET;
        end else begin
            st_q <= st_next;
        end
    end

    assign staged_flat = st_next;
endmodule

// File: rtl/xpt_active_store.sv
// Second configuration stage: on a commit it takes all staged entries at
// once. Its contents drive the routing.
// Assumes that staged_flat already holds this cycle's stage writes.
module xpt_active_store #(
    parameter int N_OUT = 8,
    parameter int IA_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [(N_OUT+1)*IA_W-1:0] staged_flat,
    output logic [(N_OUT+1)*IA_W-1:0] cfg_flat
);
    localparam int N_ENT = N_OUT + 1;
    localparam logic [IA_W-1:0] QUIET = {2'b11, {(IA_W-2){1'b0}}};

    // Copy the whole staging store on commit; reset makes every entry quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++)
                cfg_flat[i*IA_W +: IA_W] <= QUIET;
        end else if (commit) begin
            cfg_flat <= staged_flat;
        end
    end
endmodule

// File: rtl/xpt_lane_mux.sv
// Selects the source of one output lane from its active code.
// Purely combinational. Assumes that N_IN is a power of two and IA_W is
// log2(N_IN)+1.
module xpt_lane_mux
    import xpt_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int IA_W = 4
) (
    input  logic [IA_W-1:0] code,
    input  logic [N_IN-1:0] main_in,
    input  logic            exp_bit,
    output logic            lane_out
);
    localparam int SEL_W = IA_W - 1;

    logic [SEL_W-1:0] sel;
    assign sel = code[SEL_W-1:0];

    // Pick a main input, the expansion bit or the quiet level.
    always_comb begin
        unique case (kind_of(code[IA_W-1], code[IA_W-2]))
            SRC_MAIN: lane_out = main_in[sel];
            SRC_EXP:  lane_out = exp_bit;
            default:  lane_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/xpt_switch_ctrl.sv
// Crosspoint router top: the staging store feeds the active store, and one
// lane selector per output reads the active store.
// The auxiliary output is the last lane, and aux_in is its expansion bit.
module xpt_switch_ctrl #(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          main_in,
    input  logic [N_OUT-1:0]         exp_in,
    input  logic                     aux_in,
    input  logic [$clog2(N_OUT)-1:0] oa,
    input  logic [$clog2(N_IN):0]    ia,
    input  logic                     load,
    input  logic                     stage_aux,
    input  logic                     commit,
    output logic [N_OUT-1:0]         out,
    output logic                     aux_out
);
    localparam int OA_W  = $clog2(N_OUT);
    localparam int IA_W  = $clog2(N_IN) + 1;
    localparam int N_ENT = N_OUT + 1;

    logic [N_ENT*IA_W-1:0] staged_flat;
    logic [N_ENT*IA_W-1:0] cfg_flat;
    logic [N_ENT-1:0]      lanes;
    logic [N_ENT-1:0]      exp_all;

    assign exp_all = {aux_in, exp_in};

    xpt_stage_store #(.N_OUT(N_OUT), .OA_W(OA_W), .IA_W(IA_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .oa(oa), .ia(ia), .load(load),
        .stage_aux(stage_aux), .staged_flat(staged_flat)
    );

    xpt_active_store #(.N_OUT(N_OUT), .IA_W(IA_W)) u_active (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .staged_flat(staged_flat), .cfg_flat(cfg_flat)
    );

    for (genvar n = 0; n < N_ENT; n++) begin : g_lane
        xpt_lane_mux #(.N_IN(N_IN), .IA_W(IA_W)) u_mux (
            .code(cfg_flat[n*IA_W +: IA_W]), .main_in(main_in),
            .exp_bit(exp_all[n]), .lane_out(lanes[n])
        );
    end

    assign out     = lanes[N_OUT-1:0];
    assign aux_out = lanes[N_OUT];
endmodule

// File: rtl/xpt_switch_chk.sv
// Property checker for the crosspoint router, bound to its top module.
// It watches the ports and the active store that the lane selectors read.
module xpt_switch_chk #(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [N_IN-1:0]                   main_in,
    input logic [N_OUT-1:0]                  exp_in,
    input logic                              aux_in,
    input logic [$clog2(N_OUT)-1:0]          oa,
    input logic [$clog2(N_IN):0]             ia,
    input logic                              load,
    input logic                              stage_aux,
    input logic                              commit,
    input logic [N_OUT-1:0]                  out,
    input logic                              aux_out,
    input logic [(N_OUT+1)*($clog2(N_IN)+1)-1:0] cfg_flat
);
    localparam int IA_W  = $clog2(N_IN) + 1;
    localparam int N_ENT = N_OUT + 1;

    function automatic logic [IA_W-1:0] ent(
        input logic [N_ENT*IA_W-1:0] f, input int i);
        return f[i*IA_W +: IA_W];
    endfunction

    logic was_rst;
    // Remember whether reset was low at the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Outputs stay quiet while reset has been applied.
    always_ff @(posedge clk) begin
        if (was_rst)
            assert_reset_quiet_R1: assert (out == {N_OUT{1'b1}} && aux_out == 1'b1);
    end

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_flat));

    assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && commit) |=> ent(cfg_flat, int'($past(oa))) == $past(ia));

    assert_aux_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_aux && commit) |=> ent(cfg_flat, N_OUT) == $past(ia));

    logic [N_ENT-1:0] lane_o;
    logic [N_ENT-1:0] lane_e;
    assign lane_o = {aux_out, out};
    assign lane_e = {aux_in, exp_in};

    for (genvar n = 0; n < N_ENT; n++) begin : g_chk
        logic [IA_W-1:0] c;
        assign c = cfg_flat[n*IA_W +: IA_W];

        assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (c[IA_W-1:IA_W-2] == 2'b11) |-> lane_o[n]);

        assert_expansion_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (c[IA_W-1:IA_W-2] == 2'b10) |-> lane_o[n] == lane_e[n]);

        assert_main_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !c[IA_W-1] |-> lane_o[n] == main_in[c[IA_W-2:0]]);
    end
endmodule

bind xpt_switch_ctrl xpt_switch_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .main_in(main_in), .exp_in(exp_in),
    .aux_in(aux_in), .oa(oa), .ia(ia), .load(load), .stage_aux(stage_aux),
    .commit(commit), .out(out), .aux_out(aux_out), .cfg_flat(cfg_flat)
);

// File: tb/sim_xpt_switch_ctrl.sv
`timescale 1ns/1ps
module sim_xpt_switch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] main_in, exp_in;
    logic       aux_in;
    logic [2:0] oa;
    logic [3:0] ia;
    logic       load, stage_aux, commit;
    logic [7:0] out;
    logic       aux_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    logic [3:0] sh_st [9];
    logic [3:0] sh_cf [9];

    always #2 clk = ~clk;

    xpt_switch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .main_in(main_in), .exp_in(exp_in),
        .aux_in(aux_in), .oa(oa), .ia(ia), .load(load), .stage_aux(stage_aux),
        .commit(commit), .out(out), .aux_out(aux_out)
    );

    typedef struct packed {
        logic [2:0] oa;
        logic [3:0] ia;
        logic       ld;
        logic       la;
        logic       cm;
        logic [7:0] eo;
        logic       ea;
    } vec_t;

    // Data during the table: main_in=A5, exp_in=3C, aux_in=0
    localparam vec_t VT [10] = '{
        '{3'd0, 4'd1,  1'b1, 1'b0, 1'b0, 8'hFF, 1'b1},
        '{3'd1, 4'd8,  1'b1, 1'b0, 1'b0, 8'hFF, 1'b1},
        '{3'd0, 4'd9,  1'b0, 1'b1, 1'b0, 8'hFF, 1'b1},
        '{3'd0, 4'd0,  1'b0, 1'b0, 1'b1, 8'hFC, 1'b0},
        '{3'd7, 4'd6,  1'b1, 1'b0, 1'b1, 8'h7C, 1'b0},
        '{3'd0, 4'd12, 1'b1, 1'b0, 1'b0, 8'h7C, 1'b0},
        '{3'd3, 4'd3,  1'b1, 1'b0, 1'b1, 8'h75, 1'b0},
        '{3'd0, 4'd15, 1'b0, 1'b1, 1'b1, 8'h75, 1'b1},
        '{3'd2, 4'd4,  1'b1, 1'b0, 1'b1, 8'h71, 1'b1},
        '{3'd0, 4'd4,  1'b0, 1'b1, 1'b1, 8'h71, 1'b0}
    };

    function automatic string row_tag(input int r);
        case (r)
            0, 1, 2, 5: return "R3 staged only";
            3:          return "R4 R6 commit all";
            4:          return "R9 same-cycle commit";
            6:          return "R7 R2 quiet and single write";
            7:          return "R8 R7 aux quiet";
            8:          return "R2 R5 other entries kept";
            default:    return "R8 aux main source";
        endcase
    endfunction

    // Expected outputs from the active codes, per the source-code rules.
    function automatic logic [8:0] model_out();
        logic [8:0] r;
        for (int n = 0; n < 9; n++) begin
            logic [3:0] c;
            c = sh_cf[n];
            if (!c[3])      r[n] = main_in[c[2:0]];
            else if (!c[2]) r[n] = (n < 8) ? exp_in[n] : aux_in;
            else            r[n] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Apply one control cycle and update the bench's view of both stores.
    task automatic step(input logic [2:0] a, input logic [3:0] c,
                        input logic l, input logic la, input logic cm);
        oa = a; ia = c; load = l; stage_aux = la; commit = cm;
        @(posedge clk);
        if (rst_n) begin
            if (l)  sh_st[a] = c;
            if (la) sh_st[8] = c;
            if (cm) sh_cf = sh_st;
        end
        @(negedge clk);
    endtask

    task automatic quiet_all();
        for (int i = 0; i < 9; i++) begin
            sh_st[i] = 4'hC;
            sh_cf[i] = 4'hC;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; main_in = 8'hA5; exp_in = 8'h3C; aux_in = 1'b0;
        oa = '0; ia = '0; load = 0; stage_aux = 0; commit = 0;
        quiet_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", {aux_out, out}, 9'h1FF);
        rst_n = 1'b1;
        step(3'd0, 4'd0, 0, 0, 0);
        check("R1 after release", {aux_out, out}, 9'h1FF);

        for (int r = 0; r < 10; r++) begin
            step(VT[r].oa, VT[r].ia, VT[r].ld, VT[r].la, VT[r].cm);
            check(row_tag(r), {aux_out, out}, {VT[r].ea, VT[r].eo});
        end

        // R11: data changes reach the outputs without a clock edge
        for (int k = 0; k < 4; k++) begin
            #0.3 main_in = 8'($urandom); exp_in = 8'($urandom); aux_in = 1'($urandom);
            #0.3 check("R11 combinational data", {aux_out, out}, model_out());
        end

        // R5: output n from main input 7-n, aux from main input 2, one commit
        for (int n = 0; n < 8; n++) step(3'(n), 4'(7 - n), 1, 0, 0);
        step(3'd0, 4'd2, 0, 1, 1);
        for (int k = 0; k < 6; k++) begin
            main_in = 8'($urandom);
            #1 check("R5 main routing", {aux_out, out}, model_out());
            check("R5 reversed map", {aux_out, out}, {main_in[2], main_in[0], main_in[1],
                main_in[2], main_in[3], main_in[4], main_in[5], main_in[6], main_in[7]});
        end

        // R6: every output from its own expansion lane
        for (int n = 0; n < 8; n++) step(3'(n), 4'(8 + (n % 4)), 1, 0, 0);
        step(3'd0, 4'd10, 0, 1, 1);
        for (int k = 0; k < 6; k++) begin
            main_in = 8'($urandom); exp_in = 8'($urandom); aux_in = 1'($urandom);
            #1 check("R6 expansion lanes", {aux_out, out}, {aux_in, exp_in});
        end

        // R10: transparent mode follows ia each cycle on output 5
        for (int k = 0; k < 8; k++) begin
            main_in = 8'($urandom);
            step(3'd5, 4'(k), 1, 0, 1);
            check("R10 transparent", {aux_out, out}, model_out());
            check("R10 lane five", {8'h00, out[5]}, {8'h00, main_in[k]});
        end
        step(3'd5, 4'd13, 1, 0, 1);
        check("R10 transparent quiet", {8'h00, out[5]}, 9'h001);

        // R3: queued writes with commit low leave the routing alone
        for (int n = 0; n < 8; n++) step(3'(n), 4'd14, 1, 1, 0);
        main_in = 8'($urandom); exp_in = 8'($urandom);
        #1 check("R3 queued no effect", {aux_out, out}, model_out());

        // R1: a mid-run reset returns every output to quiet
        rst_n = 1'b0;
        step(3'd0, 4'd0, 1, 1, 1);
        rst_n = 1'b1;
        quiet_all();
        check("R1 mid-run reset", {aux_out, out}, 9'h1FF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule